// File: doc/BRIEF.md
# Character Row Vertical Line Scaler

This block produces the vertical timing of a fifteen-row character overlay. It counts horizontal sync leading edges from each vertical sync leading edge and waits for a programmable start delay. It then walks through the character rows. In each row, every line of the font cell is shown for one or more horizontal lines, so that the row reaches the programmed height. After the font lines it inserts a programmable number of blank spacing lines.

The height is set by a 7-bit code. The top two bits set a base multiplier. Each of the five low bits adds a fixed, spread-out set of font lines that are shown one extra time. The scaling is not done by uniform division.

For every horizontal line the block outputs a display enable, the current row index, the font line index and a flag that marks spacing lines. A pixel or character generator downstream uses these to fetch glyph lines. Sync polarity is selectable for each sync input. A new vertical sync edge restarts the whole sequence at any time.

Top module: `osd_row_vscaler`

## Requirements
- R1: After a vertical sync leading edge, the display enable first rises on the horizontal sync leading edge numbered `vdelay_i*4+1`, counting from 1 after the vertical edge. Until then it stays low.
- R2: Height code bits 6:5 set how many times each font line is shown: 3 times for `11`, 2 times for `10`, and once for `00` or `01`.
- R3: Each of the low code bits adds one extra showing to a fixed set of font lines:
  - bit 0: line 8.
  - bit 1: lines 4 and 12.
  - bit 2: lines 2, 6, 10 and 14.
  - bit 3: the odd lines 1 to 15.
- R4: A low-field value (bits 4:0) of exactly 16 adds one extra showing to lines 1 to 16. A low-field value of 17 or more is treated as 17, which adds one extra showing to lines 0 to 16.
- R5: After the font lines of a row, `row_gap_i` spacing lines follow. During them `gap_line_o` is 1, the display enable is 1 and the row index does not change. A value of 0 inserts no spacing lines.
- R6: With `font_short_i`=1, font lines 0 and 17 are skipped, so a row shows lines 1 to 16. With `font_short_i`=0, a row shows lines 0 to 17.
- R7: When bit r of `row_dbl_i` is 1, every font line of row r is held for twice the number of horizontal lines.
- R8: Rows are shown in order 0 to 14. The display enable falls on the horizontal edge that follows the last line of row 14, spacing lines included. It stays low until the next vertical sync edge.
- R9: With a polarity input at 0, the matching sync input is active low, and its falling edge is the leading edge.
- R10: A vertical sync leading edge during display drops the display enable on the next clock and restarts the delay count.
- R11: After reset, `disp_en_o`, `gap_line_o`, `row_idx_o` and `font_line_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Raw horizontal sync |
| vsync_i | input | 1 | Raw vertical sync |
| hs_pos_i | input | 1 | 1: horizontal sync is active high |
| vs_pos_i | input | 1 | 1: vertical sync is active high |
| height_code_i | input | 7 | Weighted height code |
| vdelay_i | input | 8 | Start delay, in steps of four lines |
| row_gap_i | input | 5 | Spacing lines after each row |
| row_dbl_i | input | 15 | Per-row double-height flags, bit r for row r |
| font_short_i | input | 1 | 1: skip the first and last font lines |
| disp_en_o | output | 1 | Vertical display enable |
| row_idx_o | output | 4 | Current character row |
| font_line_o | output | 5 | Current font line |
| gap_line_o | output | 1 | Current line is a spacing line |

## Verification
The assertions assume the following about the inputs:
- Vertical and horizontal leading edges never arrive on the same clock.
- The height code, spacing, double-height flags and font-size select stay constant within a frame.
- A polarity input changes only while reset is held.

The stimulus keeps within these limits. It changes configuration only before a vertical pulse, it separates the vertical and horizontal pulses by several idle clocks, and it switches polarity under reset. Each frame is swept line by line against a per-line repetition count that the bench works out from the code arithmetic.

// File: rtl/osd_vscale_pkg.sv
package osd_vscale_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_FONT  = 2'd2,
      ST_GAP   = 2'd3
   } vs_state_e;

endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic pos_i,
   output logic edge_o
);

   logic lvl;
   assign lvl = pos_i ? raw_i : ~raw_i;

   if (STAGES < 0) begin : g_bad_stages
      $error("osd_sync_edge: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl;
      end
      assign edge_o = lvl & ~prev_q;
   end else begin : g_synced
      logic [STAGES:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-1:0], lvl};
      end
      assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
   end

endmodule

// File: rtl/osd_line_repeat.sv
module osd_line_repeat #(
   parameter int FL_W   = 5,
   parameter int CODE_W = 7,
   parameter int REP_W  = 4
) (
   input  logic [FL_W-1:0]   line_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              dbl_i,
   output logic [REP_W-1:0]  rep_o
);

   if (CODE_W != 7) begin : g_bad_code
      $error("osd_line_repeat: weighted height code must be 7 bits");
   end
   if (REP_W < 4) begin : g_bad_rep
      $error("osd_line_repeat: REP_W too narrow for 3+1 doubled");
   end

   logic [4:0]       low;
   logic [4:0]       sat;
   logic             extra;
   logic [REP_W-1:0] mult;
   int               ln;

   always_comb begin
      low   = code_i[4:0];
      sat   = (low > 5'd17) ? 5'd17 : low;
      ln    = int'(line_i);
      extra = 1'b0;
      if (sat == 5'd17) begin
         extra = (ln <= 16);
      end else if (sat == 5'd16) begin
         extra = (ln >= 1) && (ln <= 16);
      end else if (ln < 16) begin
         extra = (sat[0] && ln == 8)
               | (sat[1] && (ln % 8) == 4)
               | (sat[2] && (ln % 4) == 2)
               | (sat[3] && (ln % 2) == 1);
      end
      case (code_i[CODE_W-1 -: 2])
         2'b11:   mult = REP_W'(3);
         2'b10:   mult = REP_W'(2);
         default: mult = REP_W'(1);
      endcase
      rep_o = (mult + REP_W'(extra)) << dbl_i;
   end

endmodule

// File: rtl/osd_row_vscaler.sv
module osd_row_vscaler
   import osd_vscale_pkg::*;
#(
   parameter int NUM_ROWS    = 15,
   parameter int ROW_W       = 4,
   parameter int FONT_LINES  = 18,
   parameter int FL_W        = 5,
   parameter int CODE_W      = 7,
   parameter int DLY_W       = 8,
   parameter int DLY_STEP    = 4,
   parameter int GAP_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hsync_i,
   input  logic                vsync_i,
   input  logic                hs_pos_i,
   input  logic                vs_pos_i,
   input  logic [CODE_W-1:0]   height_code_i,
   input  logic [DLY_W-1:0]    vdelay_i,
   input  logic [GAP_W-1:0]    row_gap_i,
   input  logic [NUM_ROWS-1:0] row_dbl_i,
   input  logic                font_short_i,
   output logic                disp_en_o,
   output logic [ROW_W-1:0]    row_idx_o,
   output logic [FL_W-1:0]     font_line_o,
   output logic                gap_line_o
);

   localparam int CNT_W = DLY_W + $clog2(DLY_STEP) + 1;
   localparam int REP_W = 4;
   localparam logic [FL_W-1:0]  LINE_LAST = FL_W'(FONT_LINES - 1);
   localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(NUM_ROWS - 1);

   if (FONT_LINES != 18) begin : g_bad_font
      $error("osd_row_vscaler: weighted repeat sets assume an 18-line cell");
   end
   if (NUM_ROWS < 2 || NUM_ROWS > (1 << ROW_W)) begin : g_bad_rows
      $error("osd_row_vscaler: NUM_ROWS does not fit ROW_W");
   end
   if ((1 << FL_W) < FONT_LINES) begin : g_bad_fl
      $error("osd_row_vscaler: FL_W too narrow");
   end

   logic hs_edge, vs_edge;

   osd_sync_edge #(.STAGES(SYNC_STAGES)) u_hs_edge (
      .clk(clk), .rst_n(rst_n), .raw_i(hsync_i), .pos_i(hs_pos_i), .edge_o(hs_edge)
   );
   osd_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_edge (
      .clk(clk), .rst_n(rst_n), .raw_i(vsync_i), .pos_i(vs_pos_i), .edge_o(vs_edge)
   );

   vs_state_e        state_q;
   logic [CNT_W-1:0] dly_q;
   logic [ROW_W-1:0] row_q;
   logic [FL_W-1:0]  fline_q;
   logic [REP_W-1:0] rep_left_q;
   logic [GAP_W-1:0] gap_left_q;

   logic [FL_W-1:0]     first_line, last_line;
   logic [NUM_ROWS-1:0] dbl_shift;
   logic                dbl_cur, dbl_first;
   logic [REP_W-1:0]    rep_next_line, rep_row_start;
   logic [CNT_W-1:0]    dly_load;

   assign first_line = font_short_i ? FL_W'(1) : '0;
   assign last_line  = font_short_i ? (LINE_LAST - FL_W'(1)) : LINE_LAST;
   assign dbl_shift  = row_dbl_i >> row_q;
   assign dbl_cur    = dbl_shift[0];
   assign dbl_first  = (state_q == ST_DELAY) ? row_dbl_i[0] : dbl_shift[1];
   assign dly_load   = CNT_W'(vdelay_i) * CNT_W'(DLY_STEP) + CNT_W'(1);

   osd_line_repeat #(.FL_W(FL_W), .CODE_W(CODE_W), .REP_W(REP_W)) u_rep_next (
      .line_i(fline_q + FL_W'(1)), .code_i(height_code_i), .dbl_i(dbl_cur),
      .rep_o(rep_next_line)
   );
   osd_line_repeat #(.FL_W(FL_W), .CODE_W(CODE_W), .REP_W(REP_W)) u_rep_start (
      .line_i(first_line), .code_i(height_code_i), .dbl_i(dbl_first),
      .rep_o(rep_row_start)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         dly_q      <= '0;
         row_q      <= '0;
         fline_q    <= '0;
         rep_left_q <= '0;
         gap_left_q <= '0;
      end else if (vs_edge) begin
         state_q <= ST_DELAY;
         dly_q   <= dly_load;
         row_q   <= '0;
         fline_q <= '0;
      end else if (hs_edge) begin
         case (state_q)
            ST_DELAY: begin
               if (dly_q == CNT_W'(1)) begin
                  state_q    <= ST_FONT;
                  row_q      <= '0;
                  fline_q    <= first_line;
                  rep_left_q <= rep_row_start - REP_W'(1);
               end else begin
                  dly_q <= dly_q - CNT_W'(1);
               end
            end
            ST_FONT: begin
               if (rep_left_q != '0) begin
                  rep_left_q <= rep_left_q - REP_W'(1);
               end else if (fline_q != last_line) begin
                  fline_q    <= fline_q + FL_W'(1);
                  rep_left_q <= rep_next_line - REP_W'(1);
               end else if (row_gap_i != '0) begin
                  state_q    <= ST_GAP;
                  gap_left_q <= row_gap_i - GAP_W'(1);
               end else if (row_q == ROW_LAST) begin
                  state_q <= ST_IDLE;
               end else begin
                  row_q      <= row_q + ROW_W'(1);
                  fline_q    <= first_line;
                  rep_left_q <= rep_row_start - REP_W'(1);
               end
            end
            ST_GAP: begin
               if (gap_left_q != '0) begin
                  gap_left_q <= gap_left_q - GAP_W'(1);
               end else if (row_q == ROW_LAST) begin
                  state_q <= ST_IDLE;
               end else begin
                  state_q    <= ST_FONT;
                  row_q      <= row_q + ROW_W'(1);
                  fline_q    <= first_line;
                  rep_left_q <= rep_row_start - REP_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign disp_en_o   = (state_q == ST_FONT) || (state_q == ST_GAP);
   assign gap_line_o  = (state_q == ST_GAP);
   assign row_idx_o   = row_q;
   assign font_line_o = fline_q;

   a_r8_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
      disp_en_o |-> (int'(row_idx_o) < NUM_ROWS));

   a_r1_rise_on_hsync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_en_o) |-> $past(hs_edge));

   a_r10_restart_drops: assert property (@(posedge clk) disable iff (!rst_n)
      vs_edge |=> !disp_en_o);

   a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_edge && !vs_edge) |=> ($stable(row_idx_o) && $stable(font_line_o)
                                  && $stable(disp_en_o)));

   a_r6_line_in_cell: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en_o && !gap_line_o) |-> (font_line_o <= LINE_LAST));

   a_r8_row_order: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en_o && $past(disp_en_o) && (row_idx_o != $past(row_idx_o)))
         |-> (row_idx_o == $past(row_idx_o) + ROW_W'(1)));

endmodule

// File: tb/osd_row_vscaler_tb_top.sv
module osd_row_vscaler_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync = 1'b0, vsync = 1'b0;
   logic        hs_pos = 1'b1, vs_pos = 1'b1;
   logic [6:0]  code = '0;
   logic [7:0]  vdel = '0;
   logic [4:0]  gap = '0;
   logic [14:0] dbl = '0;
   logic        shrt = 1'b0;
   logic        den, gapl;
   logic [3:0]  row;
   logic [4:0]  fl;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   osd_row_vscaler dut_i (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .hs_pos_i(hs_pos), .vs_pos_i(vs_pos), .height_code_i(code),
      .vdelay_i(vdel), .row_gap_i(gap), .row_dbl_i(dbl), .font_short_i(shrt),
      .disp_en_o(den), .row_idx_o(row), .font_line_o(fl), .gap_line_o(gapl)
   );

   function automatic int exp_rep(int n, logic [6:0] c, logic d);
      int base, w, add;
      case (c[6:5])
         2'b11:   base = 3;
         2'b10:   base = 2;
         default: base = 1;
      endcase
      w = int'(c[4:0]);
      if (w > 17) w = 17;
      add = 0;
      if (w == 17)      add = (n <= 16) ? 1 : 0;
      else if (w == 16) add = (n >= 1 && n <= 16) ? 1 : 0;
      else begin
         if (w[0] && n == 8) add = 1;
         if (w[1] && (n == 4 || n == 12)) add = 1;
         if (w[2] && (n == 2 || n == 6 || n == 10 || n == 14)) add = 1;
         if (w[3] && n < 16 && (n % 2) == 1) add = 1;
      end
      return (base + add) * (d ? 2 : 1);
   endfunction

   task automatic chk(input string tag, input int act, input int expv, input string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
      end
   endtask

   task automatic hs_line();
      @(negedge clk); hsync = hs_pos;
      repeat (3) @(negedge clk);
      hsync = ~hs_pos;
      repeat (4) @(negedge clk);
   endtask

   task automatic vs_pulse();
      @(negedge clk); vsync = vs_pos;
      repeat (3) @(negedge clk);
      vsync = ~vs_pos;
      repeat (4) @(negedge clk);
   endtask

   task automatic run_frame(input logic [6:0] c, input logic [7:0] v, input logic [4:0] g,
                            input logic [14:0] db, input logic sh, input string tag,
                            input bit skip_vs);
      int dly, first, last, lines;
      code = c; vdel = v; gap = g; dbl = db; shrt = sh;
      if (!skip_vs) vs_pulse();
      dly = int'(v) * 4 + 1;
      first = sh ? 1 : 0;
      last  = sh ? 16 : 17;
      for (int k = 1; k < dly; k++) begin
         hs_line();
         if (k == dly - 1) chk("R1", int'(den), 0, "enable before start");
      end
      for (int r = 0; r < 15; r++) begin
         lines = 0;
         for (int n = first; n <= last; n++) begin
            for (int k = 0; k < exp_rep(n, c, db[r]); k++) begin
               hs_line();
               chk(tag, {den, gapl, row, fl}, {1'b1, 1'b0, 4'(r), 5'(n)},
                   $sformatf("en/gap/row/line packed (row %0d line %0d)", r, n));
               lines++;
            end
         end
         for (int k = 0; k < int'(g); k++) begin
            hs_line();
            chk("R5", {den, gapl, row}, {1'b1, 1'b1, 4'(r)}, "spacing en/gap/row packed");
         end
      end
      hs_line();
      chk("R8", int'(den), 0, "enable after last row");
      hs_line();
      chk("R8", int'(den), 0, "enable stays low");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R11 reset state
      chk("R11", {den, gapl, row, fl}, 11'd0, "reset outputs packed");

      run_frame(7'h00, 8'd0, 5'd0, 15'h0000, 1'b0, "R2", 1'b0);
      run_frame(7'h25, 8'd2, 5'd3, 15'h0000, 1'b0, "R3", 1'b0);
      run_frame(7'h0A, 8'd1, 5'd0, 15'h5555, 1'b0, "R7", 1'b0);
      run_frame(7'h70, 8'd0, 5'd31, 15'h0000, 1'b1, "R4", 1'b0);
      run_frame(7'h7F, 8'd1, 5'd1, 15'h4001, 1'b0, "R4", 1'b0);
      run_frame(7'h01, 8'd255, 5'd0, 15'h0000, 1'b1, "R6", 1'b0);

      // R10 restart in the middle of a frame
      code = 7'h04; vdel = 8'd0; gap = 5'd2; dbl = '0; shrt = 1'b0;
      vs_pulse();
      repeat (20) hs_line();
      chk("R10", int'(den), 1, "enable before restart");
      vs_pulse();
      chk("R10", int'(den), 0, "enable after restart edge");
      run_frame(7'h04, 8'd0, 5'd2, 15'h0000, 1'b0, "R10", 1'b1);

      // R9 active-low syncs, changed under reset
      rst_n = 1'b0;
      hs_pos = 1'b0; vs_pos = 1'b0; hsync = 1'b1; vsync = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11", int'(den), 0, "enable after second reset");
      run_frame(7'h33, 8'd1, 5'd4, 15'h0F00, 1'b1, "R9", 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule